// File: doc/BRIEF.md
# DRAM CAS-before-RAS Refresh Scheduler

This block sits in a DRAM controller and keeps every row of the array refreshed using CAS-before-RAS cycles. Because the device picks the row from its own internal counter, the scheduler drives only strobes and never supplies a row address. An interval timer creates refresh demand. In distributed mode it produces one demand every `RETAIN_CYC / ROWS` clocks. In burst mode it produces `ROWS` demands once every `RETAIN_CYC` clocks. Demand is kept in a saturating pending counter. A new strobe sequence starts only when the host reports it is not busy, so demand that arrives during host traffic waits and is not lost.

Each refresh cycle follows a fixed sequence:
1. CAS falls first.
2. RAS falls `T_CSR` clocks later.
3. RAS stays low for `T_RAS` clocks.
4. Both strobes rise together, and RAS then stays high for at least `T_RP` clocks.

The write strobe stays high the whole time. `ref_busy` tells the host that the scheduler owns the strobes.

Self refresh is requested with `sr_req`. The scheduler runs one CAS-before-RAS cycle and then keeps both strobes low. Once RAS has been held for `T_RASS` clocks, it raises `sr_ack`. When `sr_req` drops, both strobes go high for `T_RPS` clocks, and `sr_ack` falls at the end of that time. Refresh demand is discarded for the whole stay in self refresh, and the timer restarts at exit. After exit, distributed mode carries on at its normal spacing. Burst mode first issues a full catch-up burst of `ROWS` back-to-back cycles.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While `rst_n` is low, `ras_n`, `cas_n` and `we_n` are 1, and `sr_ack` and `ref_busy` are 0.
- R2: Every RAS fall happens while CAS is low, and CAS has been low for exactly `T_CSR` clocks at that point. RAS is never low while CAS is high.
- R3: In an ordinary refresh cycle, RAS stays low for exactly `T_RAS` clocks, and never for less.
- R4: RAS is high for at least `T_RP` clocks before any RAS fall.
- R5: With `burst_mode`=0, refresh cycles start exactly `RETAIN_CYC/ROWS` clocks apart, giving `ROWS` cycles per `RETAIN_CYC` clocks.
- R6: No refresh cycle starts in a clock that follows a sampled `host_busy`=1. Demand raised while busy is kept, and after busy drops each queued cycle runs back to back, `T_CSR+T_RAS+T_RP+1` clocks apart.
- R7: With `burst_mode`=1, every `RETAIN_CYC` clocks the block issues `ROWS` back-to-back refresh cycles, `T_CSR+T_RAS+T_RP+1` clocks apart, and issues none in between.
- R8: After `sr_req` rises, self refresh starts with a CAS-before-RAS cycle. `sr_ack` rises only after RAS has been low for at least `T_RASS` clocks. RAS stays low and no new cycle starts while `sr_req` stays high.
- R9: After `sr_req` falls, RAS goes high and stays high for at least `T_RPS` clocks, and `sr_ack` falls only after that.
- R10: After self-refresh exit with `burst_mode`=0, the block issues no refresh cycle until one full interval has passed. With `burst_mode`=1, it immediately issues `ROWS` back-to-back cycles.
- R11: `we_n` is 1 in every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_busy | input | 1 | Host access in progress; blocks the start of a refresh |
| burst_mode | input | 1 | 0 = distributed policy, 1 = burst policy |
| sr_req | input | 1 | Self-refresh request (level) |
| sr_ack | output | 1 | Self refresh established; stays high until the exit recovery is complete |
| ref_busy | output | 1 | Scheduler owns the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |

## Verification
The timer tick and the start of a refresh cycle can land in the same clock. This happens whenever demand is already queued: one clock both adds a request and removes one from the pending counter. The bench provokes this by holding `host_busy` across five intervals and then releasing it, so that a fresh tick arrives in the middle of the catch-up run. It judges the result by the exact number of cycles in a fixed window and by their spacing of exactly ten clocks. A second overlap is the catch-up burst load at self-refresh exit against the restarted timer. That case is judged by counting exactly `ROWS` cycles after exit in burst mode, and none in distributed mode.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CSR,
    ST_RAS,
    ST_RP,
    ST_SRH,
    ST_SRX
  } cbr_state_e;
endpackage

// File: rtl/cbr_tick_gen.sv
// Interval timer: one tick per interval; the interval and the demand per tick depend on the policy.
module cbr_tick_gen #(
  parameter int ROWS       = 4096,
  parameter int RETAIN_CYC = 6400000,
  localparam int TW        = $clog2(RETAIN_CYC + 1),
  localparam int SW        = $clog2(ROWS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          burst_mode,
  input  logic          run,
  input  logic          restart,
  output logic          tick,
  output logic [SW-1:0] step
);
  localparam int INTERVAL = RETAIN_CYC / ROWS;

  logic [TW-1:0] tcnt_q, tcnt_d, period;

  always_comb begin
    period = burst_mode ? TW'(RETAIN_CYC - 1) : TW'(INTERVAL - 1);
    step   = burst_mode ? SW'(ROWS) : SW'(1);
    tcnt_d = tcnt_q;
    tick   = 1'b0;
    if (restart) begin
      tcnt_d = '0;
    end else if (run) begin
      if (tcnt_q >= period) begin
        tcnt_d = '0;
        tick   = 1'b1;
      end else begin
        tcnt_d = tcnt_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt_q <= '0;
    else        tcnt_q <= tcnt_d;
  end
endmodule

// File: rtl/cbr_pend_ctr.sv
// Saturating count of refresh cycles still owed.
module cbr_pend_ctr #(
  parameter int ROWS     = 4096,
  parameter int PEND_MAX = 8192,
  localparam int SW      = $clog2(ROWS + 1),
  localparam int CW      = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [SW-1:0] step,
  input  logic          take,
  input  logic          clear,
  input  logic          load,
  input  logic [SW-1:0] load_val,
  output logic          pend_nz
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   sum;

  always_comb begin
    sum = {1'b0, cnt_q};
    if (tick) sum = sum + (CW+1)'(step);
    if (take) sum = sum - (CW+1)'(1);
    if (clear)                        cnt_d = '0;
    else if (load)                    cnt_d = CW'(load_val);
    else if (sum > (CW+1)'(PEND_MAX)) cnt_d = CW'(PEND_MAX);
    else                              cnt_d = sum[CW-1:0];
    pend_nz = (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cbr_strobe_fsm.sv
// Strobe sequencer for refresh cycles and self-refresh entry and exit.
module cbr_strobe_fsm
  import cbr_pkg::*;
#(
  parameter int T_CSR  = 2,
  parameter int T_RAS  = 5,
  parameter int T_RP   = 4,
  parameter int T_RASS = 10000,
  parameter int T_RPS  = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_busy,
  input  logic sr_req,
  input  logic pend_nz,
  output logic take,
  output logic sr_enter,
  output logic sr_leave,
  output logic in_sr,
  output logic ras_n,
  output logic cas_n,
  output logic sr_ack,
  output logic busy
);
  localparam int M1   = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int M2   = (M1 > T_RP) ? M1 : T_RP;
  localparam int M3   = (M2 > T_RASS) ? M2 : T_RASS;
  localparam int TMAX = (M3 > T_RPS) ? M3 : T_RPS;
  localparam int CW   = $clog2(TMAX + 1);

  cbr_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sr_q, sr_d, ack_q, ack_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = (cnt_q != '0) ? cnt_q - CW'(1) : cnt_q;
    sr_d     = sr_q;
    ack_d    = ack_q;
    take     = 1'b0;
    sr_enter = 1'b0;
    sr_leave = 1'b0;
    unique case (st_q)
      ST_IDLE: if (!host_busy) begin
        if (sr_req) begin
          st_d = ST_CSR; cnt_d = CW'(T_CSR - 1); sr_d = 1'b1; sr_enter = 1'b1;
        end else if (pend_nz) begin
          st_d = ST_CSR; cnt_d = CW'(T_CSR - 1); take = 1'b1;
        end
      end
      ST_CSR: if (cnt_q == '0) begin
        st_d = ST_RAS; cnt_d = CW'(T_RAS - 1);
      end
      ST_RAS: if (cnt_q == '0) begin
        if (sr_q) begin st_d = ST_SRH; cnt_d = CW'(T_RASS - 1); end
        else      begin st_d = ST_RP;  cnt_d = CW'(T_RP - 1);   end
      end
      ST_RP: if (cnt_q == '0) st_d = ST_IDLE;
      ST_SRH: begin
        if (cnt_q == '0) ack_d = 1'b1;
        if (ack_q && !sr_req) begin st_d = ST_SRX; cnt_d = CW'(T_RPS - 1); end
      end
      ST_SRX: if (cnt_q == '0) begin
        st_d = ST_IDLE; ack_d = 1'b0; sr_d = 1'b0; sr_leave = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sr_q  <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sr_q  <= sr_d;
      ack_q <= ack_d;
    end
  end

  assign cas_n  = !(st_q == ST_CSR || st_q == ST_RAS || st_q == ST_SRH);
  assign ras_n  = !(st_q == ST_RAS || st_q == ST_SRH);
  assign in_sr  = sr_q;
  assign sr_ack = ack_q;
  assign busy   = (st_q != ST_IDLE);
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched #(
  parameter int ROWS       = 4096,
  parameter int RETAIN_CYC = 6400000,
  parameter int PEND_MAX   = 2 * ROWS,
  parameter int T_CSR      = 2,
  parameter int T_RAS      = 5,
  parameter int T_RP       = 4,
  parameter int T_RASS     = 10000,
  parameter int T_RPS      = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_busy,
  input  logic burst_mode,
  input  logic sr_req,
  output logic sr_ack,
  output logic ref_busy,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int SW = $clog2(ROWS + 1);

  logic          tick, take, sr_enter, sr_leave, in_sr, pend_nz;
  logic [SW-1:0] step, exit_load;

  assign exit_load = burst_mode ? SW'(ROWS) : '0;
  assign we_n      = 1'b1;

  cbr_tick_gen #(.ROWS(ROWS), .RETAIN_CYC(RETAIN_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode),
    .run(!in_sr), .restart(sr_leave), .tick(tick), .step(step)
  );

  cbr_pend_ctr #(.ROWS(ROWS), .PEND_MAX(PEND_MAX)) u_pend (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step(step), .take(take),
    .clear(sr_enter), .load(sr_leave), .load_val(exit_load), .pend_nz(pend_nz)
  );

  cbr_strobe_fsm #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP),
                   .T_RASS(T_RASS), .T_RPS(T_RPS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .host_busy(host_busy), .sr_req(sr_req),
    .pend_nz(pend_nz), .take(take), .sr_enter(sr_enter), .sr_leave(sr_leave),
    .in_sr(in_sr), .ras_n(ras_n), .cas_n(cas_n), .sr_ack(sr_ack), .busy(ref_busy)
  );
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
  parameter int T_CSR  = 2,
  parameter int T_RAS  = 5,
  parameter int T_RP   = 4,
  parameter int T_RASS = 10000,
  parameter int T_RPS  = 11
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic host_busy,
  input logic sr_ack
);
  logic [15:0] lowcnt, highcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowcnt  <= '0;
      highcnt <= 16'hFFFF;
    end else begin
      lowcnt  <= ras_n ? '0 : ((lowcnt  == 16'hFFFF) ? lowcnt  : lowcnt  + 16'd1);
      highcnt <= ras_n ? ((highcnt == 16'hFFFF) ? highcnt : highcnt + 16'd1) : '0;
    end
  end

  assert_cas_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && !$past(cas_n)));
  assert_ras_in_cas_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);
  assert_ras_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lowcnt >= 16'(T_RAS)));
  assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (highcnt >= 16'(T_RP)));
  assert_no_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> !$past(host_busy));
  assert_sr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_ack) |-> (!ras_n && lowcnt >= 16'(T_RASS)));
  assert_sr_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_ack) |-> (ras_n && highcnt >= 16'(T_RPS)));
endmodule

bind cbr_refresh_sched cbr_checker #(
  .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .T_RASS(T_RASS), .T_RPS(T_RPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
  .host_busy(host_busy), .sr_ack(sr_ack)
);

// File: tb/tb_cbr_refresh_sched.sv
module tb_cbr_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS   = 16;
  localparam int RETAIN = 640;
  localparam int IVL    = RETAIN / ROWS;
  localparam int T_CSR  = 2;
  localparam int T_RAS  = 4;
  localparam int T_RP   = 3;
  localparam int T_RASS = 10;
  localparam int T_RPS  = 5;
  localparam int PITCH  = T_CSR + T_RAS + T_RP + 1;

  logic clk, rst_n, host_busy, burst_mode, sr_req;
  logic sr_ack, ref_busy, ras_n, cas_n, we_n;

  cbr_refresh_sched #(.ROWS(ROWS), .RETAIN_CYC(RETAIN), .T_CSR(T_CSR), .T_RAS(T_RAS),
                      .T_RP(T_RP), .T_RASS(T_RASS), .T_RPS(T_RPS)) dut (
    .clk(clk), .rst_n(rst_n), .host_busy(host_busy), .burst_mode(burst_mode),
    .sr_req(sr_req), .sr_ack(sr_ack), .ref_busy(ref_busy), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, fails = 0;
  int cyc = 0, falls = 0, last_fall = 0, gmin = 0, gmax = 0;
  bit have_last = 0, prev_ras = 1;
  int cas_run = 0, low_run = 0, high_run = 1000;
  int v_csr = 0, v_ras = 0, v_rp = 0, v_we = 0;

  // Bench-side strobe monitor, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ras_n && prev_ras) begin
        falls++;
        if (cas_run != T_CSR) v_csr++;
        if (high_run < T_RP) v_rp++;
        if (have_last) begin
          if (cyc - last_fall < gmin) gmin = cyc - last_fall;
          if (cyc - last_fall > gmax) gmax = cyc - last_fall;
        end
        last_fall = cyc;
        have_last = 1;
      end
      if (ras_n && !prev_ras && !(low_run == T_RAS || low_run >= T_RAS + T_RASS)) v_ras++;
      if (!we_n) v_we++;
      cas_run  = cas_n ? 0 : cas_run + 1;
      low_run  = ras_n ? 0 : low_run + 1;
      high_run = ras_n ? high_run + 1 : 0;
      prev_ras = ras_n;
      cyc++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic clr_mon();
    falls = 0; have_last = 0; gmin = 1 << 30; gmax = 0;
  endtask

  task automatic wait_fall();
    int f0 = falls;
    for (int i = 0; i < 2000 && falls == f0; i++) step(1);
  endtask

  task automatic wait_ack(input bit lvl);
    for (int i = 0; i < 500 && sr_ack != lvl; i++) step(1);
    chk(sr_ack == lvl, "R8/R9 sr_ack level", sr_ack, lvl);
  endtask

  task automatic t_reset(input bit mode);
    rst_n = 0; host_busy = 0; sr_req = 0; burst_mode = mode;
    step(5);
    chk(ras_n && cas_n && we_n, "R1 strobes in reset", {ras_n, cas_n, we_n}, 7);
    chk(!sr_ack && !ref_busy, "R1 ack/busy in reset", {sr_ack, ref_busy}, 0);
    prev_ras = 1; high_run = 1000; low_run = 0; cas_run = 0;
    rst_n = 1;
    clr_mon();
  endtask

  task automatic t_distributed();
    step(655);
    chk(falls == ROWS, "R5 cycles per period", falls, ROWS);
    chk(gmin == IVL && gmax == IVL, "R5 spacing", gmax, IVL);
  endtask

  task automatic t_host_busy();
    wait_fall();
    step(1);
    host_busy = 1;
    clr_mon();
    step(199);
    chk(falls == 0, "R6 no start while busy", falls, 0);
    host_busy = 0;
    clr_mon();
    step(46);
    chk(falls == 5, "R6 queued cycles after busy", falls, 5);
    chk(gmin == PITCH && gmax == PITCH, "R6 back-to-back pitch", gmax, PITCH);
  endtask

  task automatic t_self_refresh(input bit mode);
    wait_fall();
    step(1);
    sr_req = 1;
    wait_ack(1'b1);
    chk(!ras_n && low_run >= T_RASS, "R8 RAS held before ack", low_run, T_RASS);
    clr_mon();
    step(300);
    chk(falls == 0 && !ras_n, "R8 no cycle while in self refresh", falls, 0);
    sr_req = 0;
    wait_ack(1'b0);
    chk(ras_n && high_run >= T_RPS, "R9 RAS high before exit done", high_run, T_RPS);
    clr_mon();
    if (!mode) begin
      step(30);
      chk(falls == 0, "R10 no burst after exit (distributed)", falls, 0);
    end else begin
      step(170);
      chk(falls == ROWS, "R10 catch-up burst after exit", falls, ROWS);
      chk(gmin == PITCH && gmax == PITCH, "R10 burst pitch", gmax, PITCH);
    end
  endtask

  task automatic t_burst();
    step(820);
    chk(falls == ROWS, "R7 burst count", falls, ROWS);
    chk(gmin == PITCH && gmax == PITCH, "R7 burst pitch", gmax, PITCH);
    clr_mon();
    step(200);
    chk(falls == 0, "R7 quiet between bursts", falls, 0);
  endtask

  task automatic t_widths();
    chk(v_csr == 0, "R2 CAS lead violations", v_csr, 0);
    chk(v_ras == 0, "R3 RAS width violations", v_ras, 0);
    chk(v_rp == 0, "R4 RAS precharge violations", v_rp, 0);
    chk(v_we == 0, "R11 write strobe low count", v_we, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    t_reset(1'b0);
    t_distributed();
    t_host_busy();
    t_self_refresh(1'b0);
    t_reset(1'b1);
    t_burst();
    t_self_refresh(1'b1);
    t_widths();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule